// File: doc/BRIEF.md
# Low-resolution playfield pixel generator

This block draws the background-wall layer of a raster line from a 20-bit bitmap that the host keeps in three registers: a 4-bit one and two 8-bit ones. The timing unit supplies the visible pixel column (0 to 159) and a visible flag. Each playfield pixel covers 4 colour clocks, so one copy of the 20 bits spans 80 columns. The same bits fill the right half of the line, either in the same order or mirrored.

For every column the block reports whether a playfield bit is lit. It also outputs the colour to show: the playfield colour register when the bit is lit, and the background colour register otherwise. Register contents are redrawn on every line until the host writes them again. There is no pipeline between the registers and the outputs, so a write made part-way through a line changes the pixels that follow it.

The column decode is a small combinational state selector with four named segments:
- `SEG_BLANK` applies when the visible flag is low or the column is 160 or above.
- `SEG_LEFT` applies to columns 0 to 79.
- `SEG_RIGHT_COPY` applies to columns 80 to 159 when mirroring is off.
- `SEG_RIGHT_MIRROR` applies to columns 80 to 159 when mirroring is on.

As the column sweeps a line, the segment moves from LEFT to one of the two right-half segments at column 80, and to BLANK at column 160 or whenever the visible flag drops. The mirror bit decides which right-half segment is entered.

Top module: `pf_raster_gen`

## Requirements
- R1: After reset, all registers are zero, so every column gives hit 0 and colour 0.
- R2: In columns 0 to 79, the pixel index is column/4. Pixels 0 to 3 come from bits 4, 5, 6 and 7 of address 0. Pixels 4 to 11 come from bits 7 down to 0 of address 1. Pixels 12 to 19 come from bits 0 up to 7 of address 2.
- R3: With bit 0 of the control register (address 3) clear, columns 80 to 159 show pixel column/4 − 20.
- R4: With bit 0 of address 3 set, columns 80 to 159 show pixel 19 − (column/4 − 20).
- R5: A lit pixel outputs the playfield colour (address 4). An unlit one outputs the background colour (address 5).
- R6: When the visible flag is low, or the column is 160 or above, hit is 0 and the colour is the background colour.
- R7: Register values persist and are redrawn on every line until they are rewritten.
- R8: A write takes effect at the clock edge that captures it. Outputs show the new value from that edge on, including in the middle of a line.
- R9: Bits 3:0 of address 0, bits 7:1 of address 3, and writes to addresses 6 and 7 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Colour clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 3 | Host register address |
| wr_data_i | input | 8 | Host write data |
| col_i | input | COL_W | Visible pixel column from the timing unit |
| vis_i | input | 1 | Visible region flag |
| pf_hit_o | output | 1 | Playfield bit lit at this column |
| colour_o | output | 8 | Selected colour value |

## Verification
The bench sweeps every column from 0 to 175 for a walking single bit in each of the 20 positions, with mirroring both off and on. Each single lit bit must appear in exactly one left-half pixel and in the right-half pixel that the copy or mirror rule predicts, which separates the three register bit orders and exposes any off-by-one in the halves. Dense patterns (all ones, all zeros, and mixed words) check colour selection and the repeat across lines. Blank sweeps, ignored-bit writes and writes made in the middle of a line check R6, R9 and R8 at the output pins.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int DATA_W     = 8;
    localparam int NIB_W      = 4;
    localparam int PF_PIX     = NIB_W + 2 * DATA_W;
    localparam int PIX_CLKS   = 4;
    localparam int HALF_CLKS  = PF_PIX * PIX_CLKS;
    localparam int LINE_CLKS  = 2 * HALF_CLKS;
    localparam int IDX_W      = $clog2(PF_PIX);
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_NIB   = 3'd0,
        A_MID   = 3'd1,
        A_HIGH  = 3'd2,
        A_CTRL  = 3'd3,
        A_FGCOL = 3'd4,
        A_BGCOL = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEG_BLANK,
        SEG_LEFT,
        SEG_RIGHT_COPY,
        SEG_RIGHT_MIRROR
    } seg_e;
endpackage

// File: rtl/pf_regfile.sv
module pf_regfile
    import pf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [PF_PIX-1:0] field_o,
    output logic              mirror_o,
    output logic [DATA_W-1:0] fg_o,
    output logic [DATA_W-1:0] bg_o
);
    logic [NIB_W-1:0]  nib_q;
    logic [DATA_W-1:0] mid_q;
    logic [DATA_W-1:0] high_q;
    logic              mirror_q;
    logic [DATA_W-1:0] fg_q;
    logic [DATA_W-1:0] bg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nib_q    <= '0;
            mid_q    <= '0;
            high_q   <= '0;
            mirror_q <= 1'b0;
            fg_q     <= '0;
            bg_q     <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_NIB:   nib_q    <= wr_data_i[DATA_W-1 -: NIB_W];
                A_MID:   mid_q    <= wr_data_i;
                A_HIGH:  high_q   <= wr_data_i;
                A_CTRL:  mirror_q <= wr_data_i[0];
                A_FGCOL: fg_q     <= wr_data_i;
                A_BGCOL: bg_q     <= wr_data_i;
                default: ;
            endcase
        end
    end

    // Pixel order: nibble LSB first, middle byte MSB first, high byte LSB first.
    for (genvar i = 0; i < NIB_W; i++) begin : g_nib
        assign field_o[i] = nib_q[i];
    end
    for (genvar i = 0; i < DATA_W; i++) begin : g_bytes
        assign field_o[NIB_W + i]          = mid_q[DATA_W-1-i];
        assign field_o[NIB_W + DATA_W + i] = high_q[i];
    end

    assign mirror_o = mirror_q;
    assign fg_o     = fg_q;
    assign bg_o     = bg_q;
endmodule

// File: rtl/pf_locator.sv
module pf_locator
    import pf_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] col_i,
    input  logic             vis_i,
    input  logic             mirror_i,
    output seg_e             seg_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int               PIX_SH = $clog2(PIX_CLKS);
    localparam logic [COL_W-1:0] HALF_C = COL_W'(HALF_CLKS);
    localparam logic [COL_W-1:0] LINE_C = COL_W'(LINE_CLKS);
    localparam logic [COL_W-1:0] PIX_C  = COL_W'(PF_PIX);
    localparam logic [COL_W-1:0] WRAP_C = COL_W'(2 * PF_PIX - 1);

    logic [COL_W-1:0] quo;
    assign quo = col_i >> PIX_SH;

    // Segment selection.
    always_comb begin
        if (!vis_i || col_i >= LINE_C)
            seg_o = SEG_BLANK;
        else if (col_i < HALF_C)
            seg_o = SEG_LEFT;
        else if (mirror_i)
            seg_o = SEG_RIGHT_MIRROR;
        else
            seg_o = SEG_RIGHT_COPY;
    end

    // Pixel index per segment.
    always_comb begin
        idx_o = '0;
        unique case (seg_o)
            SEG_BLANK:        idx_o = '0;
            SEG_LEFT:         idx_o = IDX_W'(quo);
            SEG_RIGHT_COPY:   idx_o = IDX_W'(quo - PIX_C);
            SEG_RIGHT_MIRROR: idx_o = IDX_W'(WRAP_C - quo);
        endcase
    end
endmodule

// File: rtl/pf_pixel_mux.sv
module pf_pixel_mux
    import pf_pkg::*;
(
    input  logic [PF_PIX-1:0] field_i,
    input  seg_e              seg_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] fg_i,
    input  logic [DATA_W-1:0] bg_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] colour_o
);
    always_comb begin
        hit_o = 1'b0;
        unique case (seg_i)
            SEG_BLANK:                                   hit_o = 1'b0;
            SEG_LEFT, SEG_RIGHT_COPY, SEG_RIGHT_MIRROR:  hit_o = field_i[idx_i];
        endcase
        colour_o = hit_o ? fg_i : bg_i;
    end
endmodule

// File: rtl/pf_raster_gen.sv
module pf_raster_gen
    import pf_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              vis_i,
    output logic              pf_hit_o,
    output logic [7:0]        colour_o
);
    logic [PF_PIX-1:0] pf_field;
    logic              mirror_en;
    logic [DATA_W-1:0] fg_colour;
    logic [DATA_W-1:0] bg_colour;
    seg_e              seg;
    logic [IDX_W-1:0]  pix_idx;

    pf_regfile u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .field_o   (pf_field),
        .mirror_o  (mirror_en),
        .fg_o      (fg_colour),
        .bg_o      (bg_colour)
    );

    pf_locator #(.COL_W(COL_W)) u_loc (
        .col_i    (col_i),
        .vis_i    (vis_i),
        .mirror_i (mirror_en),
        .seg_o    (seg),
        .idx_o    (pix_idx)
    );

    pf_pixel_mux u_mux (
        .field_i  (pf_field),
        .seg_i    (seg),
        .idx_i    (pix_idx),
        .fg_i     (fg_colour),
        .bg_i     (bg_colour),
        .hit_o    (pf_hit_o),
        .colour_o (colour_o)
    );
endmodule

// File: rtl/pf_raster_gen_chk.sv
module pf_raster_gen_chk
    import pf_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [2:0]        wr_addr_i,
    input logic [7:0]        wr_data_i,
    input logic [COL_W-1:0]  col_i,
    input logic              vis_i,
    input logic              pf_hit_o,
    input logic [7:0]        colour_o,
    input logic [PF_PIX-1:0] pf_field,
    input logic [DATA_W-1:0] fg_colour,
    input logic [DATA_W-1:0] bg_colour
);
    // R6
    blank_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vis_i || col_i >= COL_W'(LINE_CLKS)) |-> !pf_hit_o);

    // R5
    hit_colour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pf_hit_o |-> colour_o == fg_colour);

    // R5
    miss_colour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pf_hit_o |-> colour_o == bg_colour);

    // R8
    fg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_FGCOL) |=> fg_colour == $past(wr_data_i));

    // R7
    field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(pf_field));

    // R9
    unused_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i > 3'd5) |=> ($stable(pf_field) && $stable(fg_colour) && $stable(bg_colour)));
endmodule

bind pf_raster_gen pf_raster_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .col_i     (col_i),
    .vis_i     (vis_i),
    .pf_hit_o  (pf_hit_o),
    .colour_o  (colour_o),
    .pf_field  (pf_field),
    .fg_colour (fg_colour),
    .bg_colour (bg_colour)
);

// File: tb/test_pf_raster_gen.sv
module test_pf_raster_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] col = '0;
    logic       vis = 1'b0;
    logic       hit;
    logic [7:0] colour;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pf_raster_gen i_pf_raster_gen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .col_i     (col),
        .vis_i     (vis),
        .pf_hit_o  (hit),
        .colour_o  (colour)
    );

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2 bit order; low nibble of address 0 filled with junk (R9).
    task automatic load_field(input logic [19:0] v);
        logic [7:0] r0, r1, r2;
        r0 = 8'h0A;
        for (int i = 0; i < 4; i++) r0[4+i] = v[i];
        for (int i = 0; i < 8; i++) begin
            r1[7-i] = v[4+i];
            r2[i]   = v[12+i];
        end
        write_reg(3'd0, r0);
        write_reg(3'd1, r1);
        write_reg(3'd2, r2);
    endtask

    task automatic cmp(input string rq, input logic eh, input logic [7:0] ec, input int c);
        checks++;
        if (hit !== eh || colour !== ec) begin
            fails++;
            $display("FAIL %s col=%0d hit=%0b exp %0b colour=%h exp %h", rq, c, hit, eh, colour, ec);
        end
    endtask

    task automatic sweep(input logic [19:0] v, input bit mir, input logic [7:0] fg,
                         input logic [7:0] bg, input bit vv, input string note);
        for (int c = 0; c < 176; c++) begin
            int    q, idx;
            logic  eh;
            string rq;
            @(negedge clk);
            col = 8'(c); vis = vv;
            #1;
            q = c / 4;
            if (!vv || c >= 160) begin
                eh = 1'b0; rq = "R6";
            end else if (c < 80) begin
                eh = v[q]; rq = "R2";
            end else begin
                idx = mir ? 39 - q : q - 20;
                eh = v[idx]; rq = mir ? "R4" : "R3";
            end
            cmp({rq, note}, eh, eh ? fg : bg, c);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        sweep(20'h0, 1'b0, 8'h00, 8'h00, 1'b1, " R1");

        write_reg(3'd4, 8'h45);
        write_reg(3'd5, 8'h12);

        // walking single bit, copy and mirror (R2 R3 R4 R5)
        for (int k = 0; k < 20; k++) begin
            for (int m = 0; m < 2; m++) begin
                load_field(20'(1) << k);
                write_reg(3'd3, m[0] ? 8'h01 : 8'h00);
                sweep(20'(1) << k, m[0], 8'h45, 8'h12, 1'b1, " R5");
            end
        end

        // dense patterns, each swept over two lines (R7)
        begin
            logic [19:0] pats [4];
            pats[0] = 20'hFFFFF; pats[1] = 20'h00000;
            pats[2] = 20'hA5C3E; pats[3] = 20'h12345;
            for (int p = 0; p < 4; p++) begin
                for (int m = 0; m < 2; m++) begin
                    load_field(pats[p]);
                    write_reg(3'd3, m[0] ? 8'h01 : 8'h00);
                    sweep(pats[p], m[0], 8'h45, 8'h12, 1'b1, "");
                    sweep(pats[p], m[0], 8'h45, 8'h12, 1'b1, " R7");
                end
            end
        end

        // R9: control bits 7:1 ignored
        load_field(20'h12345);
        write_reg(3'd3, 8'hFE);
        sweep(20'h12345, 1'b0, 8'h45, 8'h12, 1'b1, " R9");
        write_reg(3'd3, 8'hFF);
        sweep(20'h12345, 1'b1, 8'h45, 8'h12, 1'b1, " R9");
        // R9: addresses 6 and 7 ignored
        write_reg(3'd6, 8'hFF);
        write_reg(3'd7, 8'h00);
        sweep(20'h12345, 1'b1, 8'h45, 8'h12, 1'b1, " R9");
        // R9: low nibble of address 0 alone lights nothing
        load_field(20'h0);
        write_reg(3'd0, 8'h0F);
        sweep(20'h0, 1'b1, 8'h45, 8'h12, 1'b1, " R9");

        // R6: visible low
        load_field(20'hFFFFF);
        sweep(20'hFFFFF, 1'b1, 8'h45, 8'h12, 1'b0, "");

        // R8: colour change mid-line
        write_reg(3'd3, 8'h00);
        @(negedge clk);
        col = 8'd8; vis = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h77;
        #1 cmp("R8 before edge", 1'b1, 8'h45, 8);
        @(negedge clk);
        wr_en = 1'b0;
        #1 cmp("R8 after edge", 1'b1, 8'h77, 8);
        // R8: bitmap change mid-line (pixel 5 from address 1)
        @(negedge clk);
        col = 8'd20;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00;
        #1 cmp("R8 before edge", 1'b1, 8'h77, 20);
        @(negedge clk);
        wr_en = 1'b0;
        #1 cmp("R8 after edge", 1'b0, 8'h12, 20);
        col = 8'd100;
        #1 cmp("R8 right half", 1'b0, 8'h12, 100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule